// File: doc/BRIEF.md
# Page-Mode Read Sequencer

This block is a clocked controller that sits on the host side of an asynchronous pseudo-static RAM with a 16-bit data bus, a 22-bit word address and a fast page mode. A host asks for a burst by giving a start word address and a word count from 1 to 8. The block drives the active-low select, output-enable, write-enable and byte-lane pins, waits the right number of clock cycles for each word, captures the data bus and hands each word back with a one-cycle valid strobe.

Memory pages are 8 words wide. Only the lowest three address bits may move while the part stays selected. The first word after select goes low pays the full random access time. Each later word in the same page pays only the short page access time. When a burst would run past the end of a page, the block deselects the memory for a recovery gap and reopens the next page with a full-latency access. All waits are parameters counted in clock cycles. The defaults, for a 20 ns clock, are 4 cycles for the first word, 1 cycle for each in-page word and 1 cycle of deselect recovery.

Top module: `psr_page_reader`

## Requirements
- R1: While reset is held, select and output-enable are high, `busy` is low and `rd_valid` is low.
- R2: At all times write-enable is high, the standby pin `mem_sleep_n` is high and both byte-lane selects are low, so every read returns the full 16-bit word.
- R3: A request is taken on a clock edge where `req_valid` is high and `busy` is low. Select and output-enable go low in the cycle after that edge. The first word's `rd_valid` pulse comes FIRST_CYC cycles after the accepting edge.
- R4: Each following word whose address stays inside the same 8-word page arrives PAGE_CYC cycles after the word before it.
- R5: Word i of a burst is the data bus value captured while address start+i is presented, with the address taken modulo 2^22. It is returned on `rd_data` with `rd_valid` high for one cycle per word.
- R6: When the next word's address has bits 2:0 equal to 000, select goes high for GAP_CYC cycles and the next word arrives GAP_CYC+FIRST_CYC cycles after the word before it.
- R7: While select stays low, address bits 21:3 do not change.
- R8: `busy` is high from the accepting edge until the last word's pulse. It then stays high for GAP_CYC-1 more cycles, so with the defaults it is already low when the last word is shown. A `req_valid` pulse raised while `busy` is high has no effect on the current burst and does not start another one.
- R9: `req_len` is a 4-bit count with legal values 1 to 8. A request of length N produces exactly N `rd_valid` pulses.
- R10: A burst may start at any of the eight word offsets within a page.
- R11: Between two select-low periods, including back-to-back bursts, select stays high for at least GAP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 22 | Start word address |
| req_len | input | 4 | Word count, 1 to 8 |
| busy | output | 1 | High while a burst or select recovery is in progress |
| rd_valid | output | 1 | One-cycle pulse per returned word |
| rd_data | output | 16 | Returned word |
| mem_addr | output | 22 | Memory word address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low (held high) |
| mem_lb_n | output | 1 | Lower byte lane select, active low (held low) |
| mem_ub_n | output | 1 | Upper byte lane select, active low (held low) |
| mem_sleep_n | output | 1 | Standby pin, held high for normal operation |
| mem_dq | input | 16 | Memory data bus |

## Verification
The bench records the cycle index of each accepting edge. It works out the arrival cycle of every word by arithmetic: FIRST_CYC cycles for the first word, then PAGE_CYC cycles for each in-page step, or GAP_CYC+FIRST_CYC cycles for a page crossing. It then requires each `rd_valid` pulse to land on exactly that cycle, and it samples on the falling clock edge. A memory model in the bench drives a poison value onto the data bus unless select has been low for FIRST_CYC cycles within one page and the address has been steady for PAGE_CYC cycles. A capture made too early therefore fails the data compare as well as the timing compare. The bench sweeps every start offset against every length, covers the wrap at the top of the address space, and injects requests while the block is busy.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_PAGE  = 2'd2,
    ST_GAP   = 2'd3
  } rd_state_e;
endpackage

// File: rtl/psr_wait_timer.sv
// Down counter: load sets the wait, zero flags the final cycle of it.
module psr_wait_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/psr_addr_track.sv
// Holds the word address being presented and the words still owed.
module psr_addr_track #(
  parameter int AW        = 22,
  parameter int LW        = 4,
  parameter int PAGE_BITS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          last,
  output logic          page_end
);
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;
  logic          en;

  always_comb begin
    en     = load | advance;
    addr_d = addr_q;
    left_d = left_q;
    if (load) begin
      addr_d = load_addr;
      left_d = load_len;
    end else if (advance) begin
      addr_d = addr_q + 1'b1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign addr     = addr_q;
  assign last     = (left_q == LW'(1));
  assign page_end = &addr_q[PAGE_BITS-1:0];
endmodule

// File: rtl/psr_page_reader.sv
module psr_page_reader
  import psr_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PAGE_BITS = 3,
  parameter int FIRST_CYC = 4,  // full access wait in clocks, >= 1
  parameter int PAGE_CYC  = 1,  // in-page access wait in clocks, >= 1
  parameter int GAP_CYC   = 1   // select-high recovery in clocks, >= 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_len,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic              mem_sleep_n,
  input  logic [DATA_W-1:0] mem_dq
);
  localparam int PAGE_WORDS = 1 << PAGE_BITS;
  localparam int LEN_W      = $clog2(PAGE_WORDS + 1);
  localparam int MAX_A      = (FIRST_CYC > PAGE_CYC) ? FIRST_CYC : PAGE_CYC;
  localparam int MAX_WAIT   = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int TMR_W      = $clog2(MAX_WAIT + 1);
  localparam logic [TMR_W-1:0] FIRST_LD = TMR_W'(FIRST_CYC - 1);
  localparam logic [TMR_W-1:0] PAGE_LD  = TMR_W'(PAGE_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_CYC - 1);

  rd_state_e         st_q, st_d;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              trk_load, trk_adv, trk_last, trk_page_end;
  logic [ADDR_W-1:0] trk_addr;
  logic              capture;
  logic              sel_q, sel_d;
  logic              vld_q;
  logic [DATA_W-1:0] data_q;

  psr_wait_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  psr_addr_track #(.AW(ADDR_W), .LW(LEN_W), .PAGE_BITS(PAGE_BITS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (trk_load),
    .load_addr (req_addr),
    .load_len  (LEN_W'(req_len)),
    .advance   (trk_adv),
    .addr      (trk_addr),
    .last      (trk_last),
    .page_end  (trk_page_end)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    trk_load = 1'b0;
    trk_adv  = 1'b0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && tmr_zero) begin
          st_d     = ST_FIRST;
          tmr_load = 1'b1;
          tmr_val  = FIRST_LD;
          trk_load = 1'b1;
        end
      end
      ST_FIRST, ST_PAGE: begin
        if (tmr_zero) begin
          capture  = 1'b1;
          tmr_load = 1'b1;
          if (trk_last) begin
            st_d    = ST_IDLE;
            tmr_val = GAP_LD;
          end else begin
            trk_adv = 1'b1;
            if (trk_page_end) begin
              st_d    = ST_GAP;
              tmr_val = GAP_LD;
            end else begin
              st_d    = ST_PAGE;
              tmr_val = PAGE_LD;
            end
          end
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          st_d     = ST_FIRST;
          tmr_load = 1'b1;
          tmr_val  = FIRST_LD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    sel_d = (st_d == ST_FIRST) || (st_d == ST_PAGE);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      vld_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= mem_dq;
  end

  assign busy        = (st_q != ST_IDLE) || !tmr_zero;
  assign rd_valid    = vld_q;
  assign rd_data     = data_q;
  assign mem_addr    = trk_addr;
  assign mem_cs_n    = ~sel_q;
  assign mem_oe_n    = ~sel_q;
  assign mem_we_n    = 1'b1;
  assign mem_lb_n    = 1'b0;
  assign mem_ub_n    = 1'b0;
  assign mem_sleep_n = 1'b1;

  // Run-length counters that the checks below relate to
  localparam int OR_W = $clog2(FIRST_CYC + 1);
  localparam logic [OR_W-1:0] OR_MAX  = OR_W'(FIRST_CYC);
  localparam logic [OR_W-1:0] OR_NEED = OR_W'(FIRST_CYC - 1);
  localparam int HR_W = $clog2(GAP_CYC + 1);
  localparam logic [HR_W-1:0] HR_MAX  = HR_W'(GAP_CYC);

  logic [OR_W-1:0] open_run;
  logic [HR_W-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_run <= '0;
      hi_run   <= '0;
    end else begin
      if (mem_cs_n)               open_run <= '0;
      else if (open_run != OR_MAX) open_run <= open_run + 1'b1;
      if (!mem_cs_n)              hi_run <= '0;
      else if (hi_run != HR_MAX)  hi_run <= hi_run + 1'b1;
    end
  end

  AST_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(open_run) >= OR_NEED)); // R3
  AST_CAPTURE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n)); // R5
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |->
      (mem_addr[ADDR_W-1:PAGE_BITS] == $past(mem_addr[ADDR_W-1:PAGE_BITS]))); // R7
  AST_CS_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (hi_run >= HR_MAX)); // R11
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_oe_n)); // R8
endmodule

// File: tb/tb_psr_page_reader.sv
`timescale 1ns/1ps
module tb_psr_page_reader;
  localparam int FIRST = 4;
  localparam int PAGE  = 1;
  localparam int GAP   = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [21:0] req_addr;
  logic [3:0]  req_len;
  logic        busy, rd_valid;
  logic [15:0] rd_data;
  logic [21:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_sleep_n;
  logic [15:0] mem_dq;

  always #10 clk = ~clk;

  psr_page_reader #(.FIRST_CYC(FIRST), .PAGE_CYC(PAGE), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_sleep_n(mem_sleep_n), .mem_dq(mem_dq)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int pulses = 0;
  int exp_pulses = 0;
  int pin_bad = 0;
  int gap_bad = 0;
  int page_bad = 0;
  bit done = 0;

  function automatic logic [15:0] pat(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], a[21:16], 4'h9};
  endfunction

  // Memory model: returns poison unless the access times are met
  logic        prev_low;
  logic [21:0] prev_addr;
  int          open_cnt, stab_cnt, hi_cnt;
  logic        same_page;
  int          open_inc, stab_inc;

  always_comb begin
    same_page = prev_low && !mem_cs_n && (prev_addr[21:3] == mem_addr[21:3]);
    open_inc  = mem_cs_n ? 0 : (same_page ? open_cnt + 1 : 1);
    stab_inc  = mem_cs_n ? 0 : ((same_page && prev_addr == mem_addr) ? stab_cnt + 1 : 1);
  end
  assign mem_dq = (!mem_cs_n && !mem_oe_n && open_inc >= FIRST && stab_inc >= PAGE)
                  ? pat(mem_addr) : 16'hDEAD;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= 1'b0; prev_addr <= '0; open_cnt <= 0; stab_cnt <= 0; hi_cnt <= 0;
    end else begin
      if (!mem_cs_n && !prev_low && hi_cnt < GAP) gap_bad <= gap_bad + 1;
      if (!mem_cs_n && prev_low && prev_addr[21:3] != mem_addr[21:3]) page_bad <= page_bad + 1;
      prev_low  <= !mem_cs_n;
      prev_addr <= mem_addr;
      open_cnt  <= open_inc;
      stab_cnt  <= stab_inc;
      hi_cnt    <= mem_cs_n ? hi_cnt + 1 : 0;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) pulses <= pulses + 1;
      if (mem_we_n !== 1'b1 || mem_sleep_n !== 1'b1 || mem_lb_n !== 1'b0 || mem_ub_n !== 1'b0)
        pin_bad <= pin_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [21:0] a, input int n, input bit poke);
    int t; int c0; int waited; logic [21:0] wa; bit got;
    waited = 0;
    @(negedge clk);
    while (busy && waited < 100) begin @(negedge clk); waited++; end
    req_valid = 1'b1; req_addr = a; req_len = 4'(n);
    @(negedge clk);
    c0 = cyc; req_valid = 1'b0;
    chk(!mem_cs_n && !mem_oe_n && busy, "R3 select after accept", {mem_cs_n, mem_oe_n, busy}, 3'b001);
    exp_pulses += n;
    t = 0;
    for (int i = 0; i < n; i++) begin
      wa = a + 22'(i);
      if (i == 0) t = FIRST;
      else if (wa[2:0] == 3'd0) t += GAP + FIRST;   // R6 crossing
      else t += PAGE;                               // R4 in-page step
      got = 0; waited = 0;
      while (!got && waited < 64) begin
        @(negedge clk); waited++;
        if (poke && i == 0 && waited == 1) begin
          req_valid = 1'b1; req_addr = ~a; req_len = 4'd2;   // R8 ignored while busy
        end else req_valid = 1'b0;
        if (rd_valid) got = 1;
      end
      chk(got, "R9 word arrives", int'(got), 1);
      chk(rd_data == pat(wa), "R5 R10 data", int'(rd_data), int'(pat(wa)));
      chk(cyc - c0 == t, (i == 0) ? "R3 first latency" : "R4 R6 latency", cyc - c0, t);
      if (i == n - 1)
        chk(busy == (GAP > 1), "R8 busy at last word", int'(busy), int'(GAP > 1));
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = 4'd1;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && !busy && !rd_valid, "R1 reset state",
        {mem_cs_n, mem_oe_n, busy, rd_valid}, 4'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int len = 1; len <= 8; len++) begin
      for (int off = 0; off < 8; off++) begin
        int k = (len - 1) * 8 + off;
        run_req({19'(k * 37 + 5), 3'(off)}, len, (k % 9) == 0);
      end
    end
    run_req(22'h3FFFFC, 8, 1'b0);   // wrap of the address space
    run_req(22'h3FFFFF, 2, 1'b1);
    repeat (12) @(negedge clk);
    chk(pulses == exp_pulses, "R9 R8 pulse count", pulses, exp_pulses);
    chk(pin_bad == 0, "R2 fixed pins", pin_bad, 0);
    chk(gap_bad == 0, "R11 R6 select recovery", gap_bad, 0);
    chk(page_bad == 0, "R7 upper address fixed", page_bad, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule